// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Engine

This block runs a dual-channel serial successive-approximation converter that has an active-low chip select, one serial clock and two data lines. It repeats conversion frames without pause and delivers one I/Q sample pair per frame, marked by a one-cycle valid strobe. The serial clock is made from the system clock by a programmable divider. The time chip select stays high between frames is set as a number of serial-clock periods. Both settings arrive together on one 16-bit timing configuration word.

A test mode replaces the captured words with two synthetic counters. One counter steps up and the other steps down on each sample. Logic further down the chain can then detect dropped or repeated samples without any analog input.

Top module: `adc_capture`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `adcCsN` is 1, `adcSck` is 0, `sampleValid` is 0 and `sampleI`/`sampleQ` are 0.
- R2: Each frame holds `adcCsN` low for exactly 16 serial-clock periods, which is 16 rising edges of `adcSck`. `adcSck` stays low whenever `adcCsN` is high.
- R3: One serial-clock period lasts D system-clock cycles, where D is `timingCfg[7:0]`. Each period starts with `adcSck` low for floor(D/2) cycles and ends with it high for the remaining cycles.
- R4: A divider field of 0 or 1 is treated as 2.
- R5: Between frames `adcCsN` stays high for N serial-clock periods, where N is `timingCfg[15:8]`. An N of 0 is treated as 1, so one frame-to-frame interval is (16+N)*D cycles.
- R6: Both data lines are sampled in parallel on each rising edge of `adcSck`. The first two bits of a frame are discarded. The following 14 bits form the word MSB first: `adcDataI` gives `sampleI` and `adcDataQ` gives `sampleQ`.
- R7: `sampleValid` is high for exactly one cycle per frame, in the cycle where `adcCsN` returns high. The sample words hold their value until the next strobe.
- R8: When `testMode` is 1 at the end of a frame, the outputs are two counters instead of the captured words. After reset `sampleI` starts at 0 and rises by 1 per test sample. `sampleQ` starts at 0x3FFF and falls by 1 per test sample. Both wrap modulo 2^14, and neither moves on frames captured with `testMode` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timingCfg | input | 16 | [7:0] serial-clock divider, [15:8] chip-select idle length in serial-clock periods |
| testMode | input | 1 | Replace captured samples with up/down counters |
| adcCsN | output | 1 | Converter chip select, active low |
| adcSck | output | 1 | Converter serial clock |
| adcDataI | input | 1 | Serial data line of the I channel |
| adcDataQ | input | 1 | Serial data line of the Q channel |
| sampleValid | output | 1 | One-cycle strobe for a completed I/Q pair |
| sampleI | output | 14 | I sample word |
| sampleQ | output | 14 | Q sample word |

## Verification
The frame-length and strobe properties assume `timingCfg` changes only while `adcCsN` is high. A divider change in mid-frame could cut a serial-clock period short and skip a rising edge. The bench therefore changes the configuration, and the values its converter model returns, only on the strobe cycle. At that moment the idle gap has just begun. The converter model launches each bit on the falling edge of `adcSck` and drives 1s into the two leading positions. A word that picked up those bits would therefore be wrong.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int FRAME_SCK = 16;
  localparam int LEAD_BITS = 2;

  typedef struct packed {
    logic sampleBit;  // rising serial-clock edge inside a frame
    logic frameDone;  // last serial-clock period of a frame ends
  } capStrobe_t;
endpackage

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] divCfg,
  input  logic [CFG_W-1:0] idleCfg,
  output logic             csN,
  output logic             sck,
  output capStrobe_t       strobe
);
  localparam logic [CFG_W-1:0] MIN_DIV  = CFG_W'(2);
  localparam logic [CFG_W-1:0] LAST_BIT = CFG_W'(FRAME_SCK - 1);

  logic [CFG_W-1:0] divCnt, bitCnt, divEff, halfDiv, idleEff;
  logic             active, sckQ, periodEnd;

  always_comb begin
    divEff    = (divCfg < MIN_DIV) ? MIN_DIV : divCfg;
    halfDiv   = divEff >> 1;
    idleEff   = (idleCfg == '0) ? CFG_W'(1) : idleCfg;
    periodEnd = (divCnt >= divEff - CFG_W'(1));
    strobe.sampleBit = active && (divCnt == halfDiv - CFG_W'(1));
    strobe.frameDone = active && periodEnd && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bitCnt <= '0;
      active <= 1'b0;
      sckQ   <= 1'b0;
    end else begin
      divCnt <= periodEnd ? '0 : divCnt + CFG_W'(1);
      if (!active || periodEnd) sckQ <= 1'b0;
      else if (strobe.sampleBit) sckQ <= 1'b1;
      if (periodEnd) begin
        if (active) begin
          if (bitCnt == LAST_BIT) begin
            active <= 1'b0;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + CFG_W'(1);
          end
        end else if (bitCnt >= idleEff - CFG_W'(1)) begin
          active <= 1'b1;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + CFG_W'(1);
        end
      end
    end
  end

  assign csN = !active;
  assign sck = sckQ;
endmodule

// File: rtl/adc_cap_dp.sv
module adc_cap_dp
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic              testMode,
  input  logic              dataI,
  input  logic              dataQ,
  output logic              valid,
  output logic              isTest,
  output logic [DATA_W-1:0] wordI,
  output logic [DATA_W-1:0] wordQ
);
  logic [DATA_W-1:0] shiftI, shiftQ, cntUp, cntDown;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftI  <= '0;
      shiftQ  <= '0;
      cntUp   <= '0;
      cntDown <= '1;
      valid   <= 1'b0;
      isTest  <= 1'b0;
      wordI   <= '0;
      wordQ   <= '0;
    end else begin
      if (strobe.sampleBit) begin
        shiftI <= {shiftI[DATA_W-2:0], dataI};
        shiftQ <= {shiftQ[DATA_W-2:0], dataQ};
      end
      valid <= strobe.frameDone;
      if (strobe.frameDone) begin
        isTest <= testMode;
        if (testMode) begin
          wordI   <= cntUp;
          wordQ   <= cntDown;
          cntUp   <= cntUp + DATA_W'(1);
          cntDown <= cntDown - DATA_W'(1);
        end else begin
          wordI <= shiftI;
          wordQ <= shiftQ;
        end
      end
    end
  end
endmodule

// File: rtl/adc_capture.sv
module adc_capture
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2*CFG_W-1:0] timingCfg,
  input  logic              testMode,
  output logic              adcCsN,
  output logic              adcSck,
  input  logic              adcDataI,
  input  logic              adcDataQ,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleI,
  output logic [DATA_W-1:0] sampleQ
);
  capStrobe_t strobe;
  logic       sampleIsTest;

  adc_cap_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .divCfg  (timingCfg[CFG_W-1:0]),
    .idleCfg (timingCfg[2*CFG_W-1:CFG_W]),
    .csN     (adcCsN),
    .sck     (adcSck),
    .strobe  (strobe)
  );

  adc_cap_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .testMode (testMode),
    .dataI    (adcDataI),
    .dataQ    (adcDataQ),
    .valid    (sampleValid),
    .isTest   (sampleIsTest),
    .wordI    (sampleI),
    .wordQ    (sampleQ)
  );
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              adcCsN,
  input logic              adcSck,
  input logic              sampleValid,
  input logic              sampleIsTest,
  input logic [DATA_W-1:0] sampleI,
  input logic [DATA_W-1:0] sampleQ
);
  logic [7:0]        riseCnt;
  logic              sckPrev, haveLast;
  logic [DATA_W-1:0] lastI;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt  <= '0;
      sckPrev  <= 1'b0;
      haveLast <= 1'b0;
      lastI    <= '0;
    end else begin
      sckPrev <= adcSck;
      if (adcCsN) riseCnt <= '0;
      else if (adcSck && !sckPrev) riseCnt <= riseCnt + 8'd1;
      if (sampleValid && sampleIsTest) begin
        haveLast <= 1'b1;
        lastI    <= sampleI;
      end
    end
  end

  // R2
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcCsN |-> !adcSck);
  // R2
  frame_rises_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcCsN) |-> riseCnt == 8'd16);
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
  // R7
  valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $rose(adcCsN));
  // R8
  test_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleIsTest) |-> (DATA_W'(sampleI + sampleQ) == '1));
  // R8
  test_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleIsTest && haveLast) |-> sampleI == DATA_W'(lastI + DATA_W'(1)));
endmodule

bind adc_capture adc_capture_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .adcCsN       (adcCsN),
  .adcSck       (adcSck),
  .sampleValid  (sampleValid),
  .sampleIsTest (sampleIsTest),
  .sampleI      (sampleI),
  .sampleQ      (sampleQ)
);

// File: tb/tb_adc_capture.sv
module tb_adc_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timingCfg = {8'd2, 8'd4};
  logic        testMode = 1'b0;
  logic        adcCsN, adcSck, sampleValid;
  logic        adcDataI = 1'b0, adcDataQ = 1'b0;
  logic [13:0] sampleI, sampleQ;
  logic [13:0] modelI = '0, modelQ = '0;
  int          bitIdx = 0;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_capture dut (
    .clk(clk), .rstN(rstN), .timingCfg(timingCfg), .testMode(testMode),
    .adcCsN(adcCsN), .adcSck(adcSck), .adcDataI(adcDataI), .adcDataQ(adcDataQ),
    .sampleValid(sampleValid), .sampleI(sampleI), .sampleQ(sampleQ)
  );

  // converter model: two junk 1s, then 14 bits MSB first, launched on falling SCK
  function automatic logic pickBit(logic [13:0] v, int k);
    if (k < 2) return 1'b1;
    if (k < 16) return v[15-k];
    return 1'b0;
  endfunction

  always @(negedge adcCsN) begin
    bitIdx = 0;
    adcDataI = pickBit(modelI, 0);
    adcDataQ = pickBit(modelQ, 0);
  end

  always @(negedge adcSck) if (!adcCsN) begin
    bitIdx = bitIdx + 1;
    adcDataI = pickBit(modelI, bitIdx);
    adcDataQ = pickBit(modelQ, bitIdx);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitValid(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sampleValid && n < 20000);
    if (!sampleValid) check(1'b0, "timeout waiting for strobe", n, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tResetState();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(adcCsN === 1'b1 && adcSck === 1'b0 && sampleValid === 1'b0, "R1 control pins in reset",
          {adcCsN, adcSck, sampleValid}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(adcCsN === 1'b1 && adcSck === 1'b0 && sampleValid === 1'b0 &&
          sampleI === 14'd0 && sampleQ === 14'd0, "R1 state after reset",
          {adcCsN, adcSck, sampleValid}, 3'b100);
  endtask

  task automatic tCapture(input logic [13:0] vi, input logic [13:0] vq);
    int n;
    waitValid(n);
    modelI = vi;
    modelQ = vq;
    waitValid(n);
    check(sampleI === vi, "R6 I word", sampleI, vi);
    check(sampleQ === vq, "R6 Q word", sampleQ, vq);
    @(negedge clk);
    check(sampleValid === 1'b0, "R7 strobe one cycle", sampleValid, 0);
    check(sampleI === vi, "R7 word held", sampleI, vi);
  endtask

  task automatic tPeriod(input logic [7:0] div, input logic [7:0] idle, input int expCyc, input string tag);
    int n;
    waitValid(n);
    timingCfg = {idle, div};
    waitValid(n);
    waitValid(n);
    check(n == expCyc, tag, n, expCyc);
  endtask

  task automatic tIdle(input logic [7:0] div, input logic [7:0] idle, input int expCyc, input string tag);
    int n, hi;
    waitValid(n);
    timingCfg = {idle, div};
    waitValid(n);
    hi = 0;
    while (adcCsN === 1'b1 && hi < 5000) begin
      hi++;
      @(negedge clk);
    end
    check(hi == expCyc, tag, hi, expCyc);
  endtask

  task automatic tSckShape();
    int n, hi, lo, guard;
    waitValid(n);
    timingCfg = {8'd2, 8'd5};
    waitValid(n);
    guard = 0;
    while ((adcCsN === 1'b1 || adcSck === 1'b0) && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (adcCsN === 1'b1) check(adcSck === 1'b0, "R2 SCK low in gap", adcSck, 0);
    end
    hi = 0;
    while (adcSck === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    lo = 0;
    while (adcSck === 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    check(hi == 3, "R3 SCK high time div 5", hi, 3);
    check(lo == 2, "R3 SCK low time div 5", lo, 2);
  endtask

  task automatic tTestMode();
    int n;
    testMode = 1'b1;
    doReset();
    for (int k = 0; k < 3; k++) begin
      waitValid(n);
      check(sampleI === 14'(k), "R8 up counter", sampleI, k);
      check(sampleQ === 14'(16383 - k), "R8 down counter", sampleQ, 16383 - k);
    end
    testMode = 1'b0;
    modelI = 14'h0AAA;
    modelQ = 14'h1555;
    waitValid(n);
    check(sampleI === 14'h0AAA, "R8 capture resumes", sampleI, 14'h0AAA);
    testMode = 1'b1;
    waitValid(n);
    check(sampleI === 14'd3, "R8 up counter held", sampleI, 3);
    check(sampleQ === 14'd16380, "R8 down counter held", sampleQ, 16380);
    testMode = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tResetState();
    tCapture(14'h2A5B, 14'h1234);
    tCapture(14'h3FFF, 14'h0000);
    tCapture(14'h0001, 14'h2000);
    tPeriod(8'd4, 8'd3, 76, "R3 frame interval div 4 idle 3");
    tPeriod(8'd5, 8'd2, 90, "R3 frame interval div 5 idle 2");
    tPeriod(8'd0, 8'd1, 34, "R4 divider 0 acts as 2");
    tPeriod(8'd1, 8'd1, 34, "R4 divider 1 acts as 2");
    tIdle(8'd4, 8'd3, 12, "R5 idle 3 periods");
    tIdle(8'd4, 8'd0, 4, "R5 idle 0 acts as 1");
    tSckShape();
    tCapture(14'h1C3A, 14'h05F0);
    tTestMode();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule